// File: doc/BRIEF.md
# Configurable I2S Audio Serializer

This block serializes stereo PCM sample pairs onto a three-wire serial audio link made of a bit clock (SCK), a word select (WS) and serial data (SD). A left/right pair enters through a valid/ready handshake and is buffered in a one-deep holding register. At each frame boundary the serializer moves the held pair into its output word. If no new pair has arrived by then, it sends the previous pair again. Each frame is two half-frames of 32 SCK periods. The left sample goes out in the first half and the right sample in the second. Samples are 24 bits, sent MSB first, and the bit positions after the sample are zero.

Three configuration inputs set the behaviour. The first selects whether the block generates SCK and WS itself or follows external clocks. The second selects where the MSB sits relative to the WS transition. The third selects which WS level marks the left channel. In master mode SCK is divided down from the system clock. In slave mode the external SCK and WS are synchronized into the system clock domain, and their edges pace the serializer. Configuration changes are taken only at a frame boundary, so every frame is sent with a single consistent setting.

Top module: `i2s_tx_serializer`

## Requirements
- R1: While reset is asserted: s_ready is 1, sd_out is 0, sck_out is 1 and ws_out is 1.
- R2: In master mode (cfg_master=1), sck_out has a period of DIV system clocks (default 22) and is high for DIV/2 of them.
- R3: A frame is 64 SCK periods, made of two half-frames of exactly 32 SCK periods each. In master mode, ws_out changes only on a falling SCK edge that starts a half-frame. sd_out changes only after an SCK falling edge, so it is stable at every rising edge.
- R4: With cfg_left_ws_high=0, the left sample is sent while WS is 0 and the right sample while WS is 1. With cfg_left_ws_high=1, the levels are swapped.
- R5: With cfg_first_edge=0, the bit at the first SCK rising edge of a half-frame is 0. The 24-bit sample follows, MSB first, on rising edges 2 to 25. Rising edges 26 to 32 carry 0.
- R6: With cfg_first_edge=1, the sample MSB is sent at the first SCK rising edge after the WS transition. The 24 sample bits fill rising edges 1 to 24, and rising edges 25 to 32 carry 0.
- R7: s_ready is 1 exactly when the holding register is empty. A pair is accepted on a clock where s_valid and s_ready are both 1. An accepted pair is sent in the next frame that starts after acceptance. Pairs are sent in the order they were accepted, one per frame.
- R8: If the holding register is empty at a frame boundary, the previous pair is sent again.
- R9: In slave mode (cfg_master=0):
  - ext_sck and ext_ws pass through two synchronizer flops.
  - sck_out and ws_out are held at 0.
  - Data advances on each external SCK falling edge.
  - The slot position re-aligns to every WS transition seen at an SCK rising edge.
- R10: A change of cfg_master, cfg_first_edge or cfg_left_ws_high takes effect at the next frame boundary. The frame already in progress is finished with the previous settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; master-mode SCK is divided from it |
| rst_n | input | 1 | Active-low reset |
| cfg_left_ws_high | input | 1 | 1: left sample while WS high; 0: left while WS low |
| cfg_first_edge | input | 1 | 1: MSB at first rising edge after WS change; 0: MSB one SCK later |
| cfg_master | input | 1 | 1: generate SCK and WS; 0: follow ext_sck and ext_ws |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Holding register empty, pair can be accepted |
| s_left | input | SW | Left sample |
| s_right | input | SW | Right sample |
| ext_sck | input | 1 | External bit clock for slave mode |
| ext_ws | input | 1 | External word select for slave mode |
| sck_out | output | 1 | Generated bit clock (0 in slave mode) |
| ws_out | output | 1 | Generated word select (0 in slave mode) |
| sd_out | output | 1 | Serial data |

## Verification
The bench decodes every half-frame back into samples, so internal errors become visible at the ports. A slot counter that is off by one shifts the whole word by one SCK. That doubles or halves the decoded sample and puts a 1 into the padding before the half-frame ends. A wrong holding-register flag shows up within one frame, either as a repeated pair while new data waits or as a dropped pair. A configuration latched mid-frame moves the WS change to the very next falling edge instead of one frame later. In slave mode, a lost alignment to WS corrupts every frame after it, starting with the next half-frame.

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer #(
  parameter int SW         = 24,
  parameter int HALF_SLOTS = 32,
  parameter int DIV        = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_left_ws_high,
  input  logic          cfg_first_edge,
  input  logic          cfg_master,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [SW-1:0] s_left,
  input  logic [SW-1:0] s_right,
  input  logic          ext_sck,
  input  logic          ext_ws,
  output logic          sck_out,
  output logic          ws_out,
  output logic          sd_out
);

  localparam int HDIV = DIV / 2;
  localparam int CW   = (HDIV > 1) ? $clog2(HDIV) : 1;
  localparam int SLW  = $clog2(2 * HALF_SLOTS);
  localparam int PW   = SLW - 1;
  localparam logic [SLW-1:0] LAST_SLOT = SLW'(2 * HALF_SLOTS - 1);
  localparam logic [SLW-1:0] MID_SLOT  = SLW'(HALF_SLOTS);
  localparam logic [SLW-1:0] PRE_MID   = SLW'(HALF_SLOTS - 1);
  localparam logic [PW:0]    SW_I      = (PW + 1)'(SW);
  localparam logic [CW-1:0]  DIV_TOP   = CW'(HDIV - 1);

  logic          m_act, fe_act, pol_act;
  logic [CW-1:0] div_cnt;
  logic          sck_q, ws_q, sd_q;
  logic [SLW-1:0] slot;
  logic [SW-1:0] act_l, act_r, pend_l, pend_r;
  logic          pend_full;
  logic [2:0]    sck_sy;
  logic [1:0]    ws_sy;
  logic          ws_seen;

  logic tick, slv_fall, slv_rise, fall_ev, rise_ev, bnd, take;
  logic fe_use, pol_use, nxt_bit;
  logic [SLW-1:0] nslot;
  logic [PW-1:0]  pos;
  logic [PW:0]    idx;
  logic [SW-1:0]  word, shifted;

  assign s_ready  = !pend_full;
  assign sck_out  = m_act & sck_q;
  assign ws_out   = m_act & ws_q;
  assign sd_out   = sd_q;

  assign tick     = m_act && (div_cnt == DIV_TOP);
  assign slv_fall = sck_sy[2] & ~sck_sy[1];
  assign slv_rise = ~sck_sy[2] & sck_sy[1];
  assign fall_ev  = m_act ? (tick && sck_q)  : slv_fall;
  assign rise_ev  = m_act ? (tick && !sck_q) : slv_rise;
  assign bnd      = fall_ev && (slot == LAST_SLOT);
  assign take     = bnd && pend_full;
  assign nslot    = slot + 1'b1;
  assign pos      = nslot[PW-1:0];
  assign fe_use   = bnd ? cfg_first_edge   : fe_act;
  assign pol_use  = bnd ? cfg_left_ws_high : pol_act;

  always_comb begin
    if (nslot[SLW-1]) word = act_r;
    else if (take)    word = pend_l;
    else              word = act_l;
    idx     = fe_use ? {1'b0, pos} : ({1'b0, pos} - 1'b1);
    shifted = word << idx;
    nxt_bit = (idx < SW_I) ? shifted[SW-1] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= 3'b111;
      ws_sy  <= 2'b00;
    end else begin
      sck_sy <= {sck_sy[1:0], ext_sck};
      ws_sy  <= {ws_sy[0], ext_ws};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      sck_q   <= 1'b1;
    end else if (!m_act) begin
      div_cnt <= '0;
    end else if (tick) begin
      div_cnt <= '0;
      sck_q   <= ~sck_q;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot    <= LAST_SLOT;
      sd_q    <= 1'b0;
      ws_q    <= 1'b1;
      ws_seen <= 1'b0;
    end else begin
      if (fall_ev) begin
        slot <= nslot;
        sd_q <= nxt_bit;
        ws_q <= nslot[SLW-1] ? ~pol_use : pol_use;
      end
      if (rise_ev && !m_act) begin
        ws_seen <= ws_sy[1];
        if (ws_sy[1] != ws_seen)
          slot <= (ws_sy[1] == pol_act) ? '0 : MID_SLOT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act     <= 1'b1;
      fe_act    <= 1'b0;
      pol_act   <= 1'b0;
      act_l     <= '0;
      act_r     <= '0;
      pend_l    <= '0;
      pend_r    <= '0;
      pend_full <= 1'b0;
    end else begin
      if (bnd) begin
        m_act   <= cfg_master;
        fe_act  <= cfg_first_edge;
        pol_act <= cfg_left_ws_high;
      end
      if (take) begin
        act_l     <= pend_l;
        act_r     <= pend_r;
        pend_full <= 1'b0;
      end
      if (s_valid && !pend_full) begin
        pend_l    <= s_left;
        pend_r    <= s_right;
        pend_full <= 1'b1;
      end
    end
  end

  p_take_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  p_cfg_at_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd |=> $stable({m_act, fe_act, pol_act}));

  p_sd_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_ev |=> $stable(sd_out));

  p_ws_half_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_act && fall_ev && slot != LAST_SLOT && slot != PRE_MID) |=> $stable(ws_out));

  p_lead_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_act && !fe_act && slot[PW-1:0] == '0) |-> !sd_out);

  p_tail_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_act && slot[PW-1:0] > PW'(SW)) |-> !sd_out);

endmodule

// File: tb/i2s_tx_serializer_test.sv
module i2s_tx_serializer_test;
  localparam int CLK_PERIOD = 10;
  localparam int BDIV = 4;
  localparam int SW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_left_ws_high = 1'b0, cfg_first_edge = 1'b0, cfg_master = 1'b1;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [SW-1:0] s_left = '0, s_right = '0;
  logic ext_sck = 1'b1, ext_ws = 1'b1;
  logic sck_out, ws_out, sd_out;

  i2s_tx_serializer #(.SW(SW), .HALF_SLOTS(32), .DIV(BDIV)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_left_ws_high(cfg_left_ws_high), .cfg_first_edge(cfg_first_edge),
    .cfg_master(cfg_master),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .ext_sck(ext_sck), .ext_ws(ext_ws),
    .sck_out(sck_out), .ws_out(ws_out), .sd_out(sd_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, errors = 0;
  bit feed_on = 0, allow_rep = 1, mon_slave = 0, exp_fe = 0, exp_pol = 0, gen_pol = 0;
  int skip = 2, nframes = 0;
  string ph_tag = "R3 R4 R5 R7";

  logic [2*SW-1:0] q [0:63];
  int qh = 0, qt = 0, qn = 0;
  logic [2*SW-1:0] last_pair = '0;

  logic [31:0] hb = '0;
  int nb = 0;
  logic wlast = 1'b1, psck = 1'b1, lpad = 1'b0;
  bit have_left = 0;
  logic [SW-1:0] lv = '0;

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] dec_sample(input logic [31:0] h, input bit fe);
    return fe ? h[31:8] : h[30:7];
  endfunction

  function automatic bit dec_pad_ok(input logic [31:0] h, input bit fe);
    return fe ? (h[7:0] == 8'h0) : (h[31] == 1'b0 && h[6:0] == 7'h0);
  endfunction

  task automatic end_frame(input logic [SW-1:0] rv, input bit pad_ok);
    logic [2*SW-1:0] pair;
    pair = {lv, rv};
    nframes++;
    if (skip > 0) begin
      skip--;
      if (qn > 0 && pair == q[qh]) begin
        last_pair = pair; qh = (qh + 1) % 64; qn--;
      end
    end else if (!pad_ok) begin
      check(0, ph_tag, "nonzero padding bits", pair, pair);
    end else if (qn > 0 && pair == q[qh]) begin
      check(1, ph_tag, "frame", pair, q[qh]);
      last_pair = pair; qh = (qh + 1) % 64; qn--;
    end else if (pair == last_pair && allow_rep) begin
      check(1, "R8", "repeated frame", pair, last_pair);
    end else begin
      check(0, ph_tag, "frame content", pair, (qn > 0) ? q[qh] : last_pair);
    end
  endtask

  task automatic end_half();
    logic [SW-1:0] smp;
    bit pk;
    if (nb != 32) begin
      if (skip == 0) check(0, "R3", "half-frame length", nb, 32);
      have_left = 0;
      return;
    end
    smp = dec_sample(hb, exp_fe);
    pk = dec_pad_ok(hb, exp_fe);
    if (wlast == exp_pol) begin
      lv = smp; lpad = pk; have_left = 1;
    end else if (have_left) begin
      have_left = 0;
      end_frame(smp, pk && lpad);
    end
  endtask

  initial forever begin
    logic sv, wv;
    @(negedge clk);
    sv = mon_slave ? ext_sck : sck_out;
    wv = mon_slave ? ext_ws : ws_out;
    if (rst_n && sv && !psck) begin
      if (wv != wlast) begin
        if (nb > 0) end_half();
        nb = 0;
        hb = '0;
      end
      if (nb < 32) hb[31 - nb] = sd_out;
      nb++;
      wlast = wv;
    end
    psck = sv;
  end

  initial forever begin
    @(negedge clk);
    if (s_valid) begin
      q[qt] = {s_left, s_right}; qt = (qt + 1) % 64; qn++;
      s_valid = 1'b0;
    end else if (feed_on && s_ready && rst_n) begin
      s_left  = SW'($urandom);
      s_right = SW'($urandom);
      s_valid = 1'b1;
    end
  end

  initial begin
    int gslot = 0;
    forever begin
      repeat (6) @(posedge clk);
      #1;
      ext_sck = ~ext_sck;
      if (!ext_sck) begin
        gslot = (gslot + 1) % 64;
        ext_ws = (gslot < 32) ? gen_pol : ~gen_pol;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog R1..R10 not reached: actual timeout expected completion");
    finish_sim();
  end

  task automatic wait_frames(input int n);
    int target;
    target = nframes + n;
    while (nframes < target) @(negedge clk);
  endtask

  task automatic steady(input string tag);
    ph_tag = tag;
    wait_frames(3);
    feed_on = 1;
    wait_frames(2);
    allow_rep = 0;
    wait_frames(5);
  endtask

  task automatic reconfig(input bit fe, input bit pol, input bit m, input string tag);
    feed_on = 0;
    allow_rep = 1;
    wait_frames(3);
    skip = m ? 3 : 4;
    ph_tag = "R8";
    cfg_first_edge = fe; cfg_left_ws_high = pol; cfg_master = m;
    exp_fe = fe; exp_pol = pol; gen_pol = pol; mon_slave = !m;
    wait_frames(skip);
    steady(tag);
  endtask

  initial begin
    $urandom(32'h5eed1234);
    repeat (3) @(negedge clk);
    check(s_ready == 1'b1, "R1", "s_ready in reset", s_ready, 1);
    check(sd_out == 1'b0, "R1", "sd_out in reset", sd_out, 0);
    check(sck_out == 1'b1, "R1", "sck_out in reset", sck_out, 1);
    check(ws_out == 1'b1, "R1", "ws_out in reset", ws_out, 1);
    @(negedge clk); rst_n = 1'b1;

    begin
      int per, hi;
      logic p;
      p = sck_out;
      while (!(sck_out && !p)) begin p = sck_out; @(negedge clk); end
      per = 0; hi = 0;
      do begin
        p = sck_out; @(negedge clk); per++;
        if (p) hi++;
      end while (!(sck_out && !p));
      check(per == BDIV, "R2", "sck period", per, BDIV);
      check(hi == BDIV / 2, "R2", "sck high time", hi, BDIV / 2);
    end

    steady("R3 R4 R5 R7");

    feed_on = 0;
    allow_rep = 1;
    wait_frames(3);
    skip = 3;
    ph_tag = "R8";
    begin
      logic pw, ps;
      int falls;
      pw = ws_out;
      @(negedge clk);
      while (!(ws_out && !pw)) begin pw = ws_out; @(negedge clk); end
      cfg_left_ws_high = 1'b1; exp_pol = 1'b1; gen_pol = 1'b1;
      falls = 0;
      ps = sck_out;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        if (ps && !sck_out) begin
          falls++;
          if (!ws_out) break;
        end
        ps = sck_out;
      end
      check(falls == 64, "R10", "falls until new polarity takes hold", falls, 64);
    end
    wait_frames(skip);
    steady("R4 R5 R7");

    reconfig(1'b1, 1'b1, 1'b1, "R4 R6 R7");
    reconfig(1'b0, 1'b0, 1'b0, "R9 R5");
    for (int i = 0; i < 8; i++) begin
      repeat (37) @(negedge clk);
      check(sck_out == 1'b0 && ws_out == 1'b0, "R9", "outputs quiet in slave",
            {sck_out, ws_out}, 0);
    end
    reconfig(1'b1, 1'b0, 1'b0, "R9 R6");

    feed_on = 0;
    repeat (4) @(negedge clk);
    finish_sim();
  end
endmodule